// File: doc/BRIEF.md
# Shadow Return-Address Checker

This block keeps a private, hardware-only copy of the return addresses pushed by near calls and checks each near return against it. When a call is retired, the block zero-extends the 16-bit return IP to a 32-bit shadow entry and pushes it onto a small internal LIFO. When a near return is retired, it pops the top entry and compares it with the zero-extended IP that the return took from the ordinary stack. A difference, or a return with nothing left to pop, raises a control-protection fault with an error code that marks a near-return violation.

Checking is switched on per privilege level. A parameter mask holds one bit per level, and the current level selects a bit. While the selected bit is clear, call and return strobes are ignored. A relative call with a zero displacement is a call to the next instruction, which code uses to read its own IP. It never returns, so it leaves the shadow stack alone. Indirect calls always push. A push onto a full shadow stack is dropped and sets a sticky overflow flag.

Top module: `shadow_ret_guard`

## Requirements
- R1: An enabled call that pushes stores the return IP zero-extended to a 32-bit entry. A later enabled return with the same IP pops that entry without a fault.
- R2: A relative call (`call_kind` = 0) with `call_disp` = 0 pushes nothing. An indirect call (`call_kind` = 1) pushes whatever its `call_disp` value is.
- R3: An enabled return pops the top entry. If that entry differs from the zero-extended `ret_ip`, `cp_fault` is high for exactly the one cycle after the return strobe. The entry is consumed either way.
- R4: While `cp_fault` is high, `cp_code` is 16'h0001 (near-return violation). At all other times `cp_code` is 0.
- R5: Checking is enabled when bit `priv_lvl` of parameter ENABLE_MASK is 1. The default 4'b1000 enables level 3 only.
- R6: An enabled return on an empty shadow stack raises the same fault, one cycle later.
- R7: Reset empties the shadow stack and clears `cp_fault`, `cp_code` and `shadow_ovf`. The stack holds DEPTH entries (default 16) in last-in, first-out order.
- R8: While checking is disabled, call and return strobes push nothing, pop nothing and never fault.
- R9: A push onto a full stack is dropped and the entries already stored are kept. `shadow_ovf` rises one cycle later and stays high until reset.
- R10: When a call and a return are strobed in the same cycle, the return is checked against the current top first. The call's entry is then pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | PRIV_W | Current privilege level |
| call_vld | input | 1 | A near call retires this cycle |
| call_kind | input | 1 | 0 = relative call, 1 = indirect call |
| call_disp | input | IP_W | Displacement of a relative call |
| call_ret_ip | input | IP_W | Return IP that the call pushes |
| ret_vld | input | 1 | A near return retires this cycle |
| ret_ip | input | IP_W | IP that the return popped from the ordinary stack |
| cp_fault | output | 1 | Control-protection fault, one-cycle pulse |
| cp_code | output | CODE_W | Fault error code |
| shadow_ovf | output | 1 | Sticky shadow-stack overflow |

## Verification
Every result is registered. The fault pulse, its code and the overflow flag for a strobe presented before a rising edge all appear right after that edge, one cycle after the stimulus. The bench drives each stimulus on a falling edge and samples the outputs on the next falling edge, so every vector is checked against its own response and against no neighbour's. The contents of the stack are never read directly. The bench infers what each strobe stored, or left alone, from the fault response of the returns that follow.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    localparam int CODE_W = 16;
    localparam logic [CODE_W-1:0] CP_NEAR_RET = 16'h0001;

    typedef enum logic {
        CALL_REL = 1'b0,
        CALL_IND = 1'b1
    } call_kind_e;
endpackage

// File: rtl/rstk_gate.sv
module rstk_gate #(
    parameter int PRIV_W = 2,
    parameter int DISP_W = 16,
    parameter logic [(1<<PRIV_W)-1:0] ENABLE_MASK = '1
) (
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              call_vld,
    input  logic              call_kind,
    input  logic [DISP_W-1:0] call_disp,
    input  logic              ret_vld,
    output logic              push_req,
    output logic              pop_req
);
    import rstk_pkg::*;

    logic en;
    logic needs_push;

    always_comb begin
        en         = ENABLE_MASK[priv_lvl];
        needs_push = (call_kind == CALL_IND) || (call_disp != '0);
        push_req   = en && call_vld && needs_push;
        pop_req    = en && ret_vld;
    end
endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 32,
    localparam int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop_req,
    output logic [ENTRY_W-1:0] top_entry,
    output logic               empty,
    output logic               full,
    output logic               push_drop,
    output logic [PTR_W-1:0]   cnt
);
    typedef struct packed {
        logic [PTR_W-1:0]              cnt;
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;
    logic [PTR_W-1:0] base;

    always_comb begin
        empty = (st_q.cnt == '0);
        full  = (st_q.cnt == PTR_W'(DEPTH));
        top_entry = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (st_q.cnt == PTR_W'(k + 1)) top_entry = st_q.mem[k];
        end
    end

    always_comb begin
        st_d = st_q;
        base = (pop_req && !empty) ? st_q.cnt - PTR_W'(1) : st_q.cnt;
        push_drop = push_req && (base == PTR_W'(DEPTH));
        st_d.cnt = base;
        if (push_req && !push_drop) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (base == PTR_W'(k)) st_d.mem[k] = push_data;
            end
            st_d.cnt = base + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/rstk_check.sv
module rstk_check #(
    parameter int ENTRY_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pop_req,
    input  logic                        empty,
    input  logic [ENTRY_W-1:0]          top_entry,
    input  logic [ENTRY_W-1:0]          ret_entry,
    input  logic                        push_drop,
    output logic                        fault,
    output logic [rstk_pkg::CODE_W-1:0] code,
    output logic                        ovf
);
    import rstk_pkg::*;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic              ovf;
    } chk_t;

    chk_t ck_d, ck_q;

    always_comb begin
        ck_d       = ck_q;
        ck_d.fault = pop_req && (empty || (top_entry != ret_entry));
        ck_d.code  = ck_d.fault ? CP_NEAR_RET : '0;
        ck_d.ovf   = ck_q.ovf || push_drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    assign fault = ck_q.fault;
    assign code  = ck_q.code;
    assign ovf   = ck_q.ovf;
endmodule

// File: rtl/shadow_ret_guard.sv
module shadow_ret_guard #(
    parameter int PRIV_W  = 2,
    parameter int IP_W    = 16,
    parameter int ENTRY_W = 32,
    parameter int DEPTH   = 16,
    parameter logic [(1<<PRIV_W)-1:0] ENABLE_MASK = 4'b1000,
    localparam int PTR_W  = $clog2(DEPTH + 1),
    localparam int CODE_W = rstk_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              call_vld,
    input  logic              call_kind,
    input  logic [IP_W-1:0]   call_disp,
    input  logic [IP_W-1:0]   call_ret_ip,
    input  logic              ret_vld,
    input  logic [IP_W-1:0]   ret_ip,
    output logic              cp_fault,
    output logic [CODE_W-1:0] cp_code,
    output logic              shadow_ovf
);
    logic               push_req, pop_req;
    logic [ENTRY_W-1:0] push_entry, ret_entry, top_entry;
    logic               stk_empty, stk_full, push_drop;
    logic [PTR_W-1:0]   stk_cnt;

    assign push_entry = ENTRY_W'(call_ret_ip);
    assign ret_entry  = ENTRY_W'(ret_ip);

    rstk_gate #(.PRIV_W(PRIV_W), .DISP_W(IP_W), .ENABLE_MASK(ENABLE_MASK)) u_gate (
        .priv_lvl (priv_lvl),
        .call_vld (call_vld),
        .call_kind(call_kind),
        .call_disp(call_disp),
        .ret_vld  (ret_vld),
        .push_req (push_req),
        .pop_req  (pop_req)
    );

    rstk_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .push_data(push_entry),
        .pop_req  (pop_req),
        .top_entry(top_entry),
        .empty    (stk_empty),
        .full     (stk_full),
        .push_drop(push_drop),
        .cnt      (stk_cnt)
    );

    rstk_check #(.ENTRY_W(ENTRY_W)) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_req  (pop_req),
        .empty    (stk_empty),
        .top_entry(top_entry),
        .ret_entry(ret_entry),
        .push_drop(push_drop),
        .fault    (cp_fault),
        .code     (cp_code),
        .ovf      (shadow_ovf)
    );
endmodule

// File: rtl/shadow_ret_guard_chk.sv
module shadow_ret_guard_chk #(
    parameter int PRIV_W = 2,
    parameter int IP_W   = 16,
    parameter int DEPTH  = 16,
    parameter logic [(1<<PRIV_W)-1:0] ENABLE_MASK = 4'b1000,
    parameter int PTR_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PRIV_W-1:0] priv_lvl,
    input logic              call_vld,
    input logic              call_kind,
    input logic [IP_W-1:0]   call_disp,
    input logic              ret_vld,
    input logic              cp_fault,
    input logic [15:0]       cp_code,
    input logic              shadow_ovf,
    input logic              push_req,
    input logic              pop_req,
    input logic              stk_full,
    input logic [PTR_W-1:0]  stk_cnt
);
    p_code_with_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_code == (cp_fault ? 16'h0001 : 16'h0000));

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ENABLE_MASK[priv_lvl] || !ret_vld) |=> !cp_fault);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_ovf |=> shadow_ovf);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= PTR_W'(DEPTH));

    p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !stk_full) |=> stk_cnt == $past(stk_cnt) + PTR_W'(1));

    p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && stk_cnt != '0) |=> stk_cnt == $past(stk_cnt) - PTR_W'(1));

    p_zero_rel_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_vld && !call_kind && call_disp == '0 && !ret_vld) |=> stk_cnt == $past(stk_cnt));
endmodule

bind shadow_ret_guard shadow_ret_guard_chk #(
    .PRIV_W(PRIV_W), .IP_W(IP_W), .DEPTH(DEPTH),
    .ENABLE_MASK(ENABLE_MASK), .PTR_W(PTR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .call_vld(call_vld),
    .call_kind(call_kind), .call_disp(call_disp), .ret_vld(ret_vld),
    .cp_fault(cp_fault), .cp_code(cp_code), .shadow_ovf(shadow_ovf),
    .push_req(push_req), .pop_req(pop_req), .stk_full(stk_full), .stk_cnt(stk_cnt)
);

// File: tb/shadow_ret_guard_tb_top.sv
module shadow_ret_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_lvl = 2'd3;
    logic        call_vld = 1'b0, call_kind = 1'b0, ret_vld = 1'b0;
    logic [15:0] call_disp = '0, call_ret_ip = '0, ret_ip = '0;
    logic        cp_fault, shadow_ovf;
    logic [15:0] cp_code;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    shadow_ret_guard dut_i (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl),
        .call_vld(call_vld), .call_kind(call_kind), .call_disp(call_disp),
        .call_ret_ip(call_ret_ip), .ret_vld(ret_vld), .ret_ip(ret_ip),
        .cp_fault(cp_fault), .cp_code(cp_code), .shadow_ovf(shadow_ovf)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  priv;
        logic        cv;
        logic        kind;
        logic [15:0] disp;
        logic [15:0] cip;
        logic        rv;
        logic [15:0] rip;
        logic        ef;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  2'd3, 1'b1, 1'b1, 16'h0000, 16'h1234, 1'b0, 16'h0000, 1'b0}, // R1 push
        '{4'd1,  2'd3, 1'b1, 1'b0, 16'h0005, 16'h0100, 1'b0, 16'h0000, 1'b0}, // R1 rel push
        '{4'd7,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0100, 1'b0}, // R7 LIFO
        '{4'd7,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h1234, 1'b0}, // R7 LIFO
        '{4'd6,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R6 empty
        '{4'd2,  2'd3, 1'b1, 1'b0, 16'h0000, 16'h0200, 1'b0, 16'h0000, 1'b0}, // R2 zero disp
        '{4'd2,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0200, 1'b1}, // R2 nothing pushed
        '{4'd2,  2'd3, 1'b1, 1'b1, 16'h0000, 16'h0300, 1'b0, 16'h0000, 1'b0}, // R2 indirect pushes
        '{4'd3,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0301, 1'b1}, // R3 mismatch
        '{4'd3,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0300, 1'b1}, // R3 consumed
        '{4'd8,  2'd0, 1'b1, 1'b1, 16'h0000, 16'h0400, 1'b0, 16'h0000, 1'b0}, // R8 call off
        '{4'd8,  2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0555, 1'b0}, // R8 ret off
        '{4'd8,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0400, 1'b1}, // R8 no push
        '{4'd8,  2'd3, 1'b1, 1'b1, 16'h0000, 16'h0500, 1'b0, 16'h0000, 1'b0}, // R8 setup
        '{4'd8,  2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0999, 1'b0}, // R8 ret off
        '{4'd8,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0500, 1'b0}, // R8 no pop
        '{4'd5,  2'd1, 1'b1, 1'b1, 16'h0000, 16'h0600, 1'b0, 16'h0000, 1'b0}, // R5 level1 off
        '{4'd5,  2'd2, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0600, 1'b0}, // R5 level2 off
        '{4'd10, 2'd3, 1'b1, 1'b1, 16'h0000, 16'h0700, 1'b0, 16'h0000, 1'b0}, // R10 setup
        '{4'd10, 2'd3, 1'b1, 1'b1, 16'h0000, 16'h0800, 1'b1, 16'h0700, 1'b0}, // R10 both
        '{4'd10, 2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0800, 1'b0}, // R10 new top
        '{4'd6,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R6 empty
        '{4'd10, 2'd3, 1'b1, 1'b1, 16'h0000, 16'h0900, 1'b1, 16'h0900, 1'b1}, // R10 empty first
        '{4'd10, 2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0900, 1'b0}, // R10 then pushed
        '{4'd6,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'hFFFF, 1'b1}, // R6 empty
        '{4'd1,  2'd3, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 1'b0}, // R1 top IP
        '{4'd1,  2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'hFFFF, 1'b0}  // R1 match
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] pv, input logic cv, input logic kd,
                        input logic [15:0] dp, input logic [15:0] cip,
                        input logic rv, input logic [15:0] rip);
        priv_lvl = pv; call_vld = cv; call_kind = kd; call_disp = dp;
        call_ret_ip = cip; ret_vld = rv; ret_ip = rip;
        @(posedge clk);
        @(negedge clk);
        call_vld = 1'b0; ret_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R7: reset state
        check("R7", "fault after reset", 32'(cp_fault), 32'd0);
        check("R7", "code after reset", 32'(cp_code), 32'd0);
        check("R7", "ovf after reset", 32'(shadow_ovf), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            step(VECS[i].priv, VECS[i].cv, VECS[i].kind, VECS[i].disp,
                 VECS[i].cip, VECS[i].rv, VECS[i].rip);
            check(tag, $sformatf("vec %0d fault", i), 32'(cp_fault), 32'(VECS[i].ef));
            check("R4", $sformatf("vec %0d code", i), 32'(cp_code),
                  VECS[i].ef ? 32'h1 : 32'h0);
        end
        // R4: the pulse lasts one cycle
        step(2'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0);
        check("R3", "fault is one cycle", 32'(cp_fault), 32'd0);

        // R9: fill to DEPTH, then one more push
        do_reset();
        for (int k = 0; k < 16; k++) begin
            step(2'd3, 1'b1, 1'b1, 16'h0, 16'(16'h1000 + k), 1'b0, 16'h0);
        end
        check("R9", "no ovf when just full", 32'(shadow_ovf), 32'd0);
        step(2'd3, 1'b1, 1'b1, 16'h0, 16'hAAAA, 1'b0, 16'h0);
        check("R9", "ovf after full push", 32'(shadow_ovf), 32'd1);
        for (int k = 15; k >= 0; k--) begin
            step(2'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 16'(16'h1000 + k));
            check("R9", $sformatf("kept entry %0d", k), 32'(cp_fault), 32'd0);
        end
        check("R9", "ovf sticky", 32'(shadow_ovf), 32'd1);
        step(2'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 16'hAAAA);
        check("R9", "dropped entry absent", 32'(cp_fault), 32'd1);
        do_reset();
        check("R7", "ovf cleared by reset", 32'(shadow_ovf), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule